// File: doc/BRIEF.md
# Sparse Channel Readout Serializer

This block sits between a bank of analogue channels and a single serial data line. A fixed-length sample period, set in system clocks, drives a scan over the channels. At each period boundary the scan picks the lowest-numbered channel that still has a readout request in the current frame. That channel is either a hit above the energy threshold or a neighbour of one. Channels with no request cost no period at all. The picked channel's address is presented to the converter's multiplexer. Its rise-time and timestamp values are captured at the same boundary.

The converter result comes back a fixed number of periods later. At that boundary it is merged with the stored metadata into one 34-bit word. The word is then shifted out MSB first, one bit per clock, across the following period, with a valid strobe. Each word fills the period after the one in which it was assembled, so no queue is needed and consecutive words leave with no idle clock between them. When every request of a frame has been served, the next boundary loads a fresh request and hit vector, and that period carries no selection.

Top module: `sparse_readout_serializer`

## Requirements
- R1: While `rst_n` is low, `dout`, `dout_valid` and `conv_go` are all 0.
- R2: A word is shifted MSB first and is laid out, from MSB down, as hit flag (1 bit), channel number (7 bits), rise time (6 bits), timestamp (8 bits), converter result (12 bits), 34 bits in all.
- R3: `dout_valid` is high for exactly the first 34 clocks after a boundary whose word carries a channel, and it stays low for the whole period when no channel is carried.
- R4: Within a frame, requested channels are picked one per period in strictly ascending order. Channels whose request bit is 0 are never picked and take up no period.
- R5: At a boundary where no request of the current frame is left, `req_in` and `hit_in` are loaded as the new frame and no channel is picked. Changes on `req_in` and `hit_in` at any other boundary have no effect.
- R6: The rise-time and timestamp fields are the values on `rise_in` and `ts_in` at the boundary where the channel is picked (while `pick_ch` shows that channel). The result field is the value on `adc_in` exactly ADC_LAT boundaries later (default 2). The word is loaded at that later boundary.
- R7: When words are carried in consecutive periods, `dout_valid` has no low clock between them.
- R8: The hit flag is 1 when the channel's bit in the frame's hit vector was 1 at the load, and 0 when it was read only as a neighbour.
- R9: After a picking boundary, `conv_go` is 1 and `conv_ch` holds the picked channel for the whole period. After a load boundary `conv_go` is 0. Both change only at boundaries.
- R10: Boundaries fall every PERIOD clocks (default 34). The first is the PERIOD-th rising edge after reset is released, and the MSB of a word appears on the clock edge of the boundary that loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | NUM_CH | Readout request per channel (hit or neighbour), sampled at a frame load |
| hit_in | input | NUM_CH | Above-threshold flag per channel, sampled at a frame load |
| pick_ch | output | 7 | Channel that the next picking boundary will take; addresses the metadata mux |
| rise_in | input | 6 | Rise-time value for `pick_ch` |
| ts_in | input | 8 | Timestamp value for `pick_ch` |
| conv_ch | output | 7 | Channel routed to the converter in this period |
| conv_go | output | 1 | A channel is being converted in this period |
| adc_in | input | 12 | Converter result, ADC_LAT periods after the channel was picked |
| dout | output | 1 | Serial word data, MSB first |
| dout_valid | output | 1 | Marks the clocks that carry word bits |

## Verification
The scan is driven with request vectors of several shapes: a lone channel at each end of the range, a sparse mix of hits and neighbours, a dense contiguous block, every channel at once, and no channel at all. Lone channels show that the edge channels are neither lost nor misnumbered. The sparse mix separates the hit flag from the request and shows that skipped channels cost no period. The full vector shows words running back to back without a gap for a whole frame. The empty vector keeps the line silent through repeated loads. In a further run the request and hit vectors change in the middle of a frame, which shows that only the next load picks them up. Because the converter value is a function of the channel, any slip in the latency alignment shows up as a field mismatch.

// File: rtl/sro_pkg.sv
package sro_pkg;

    localparam int unsigned CH_W   = 7;
    localparam int unsigned RISE_W = 6;
    localparam int unsigned TS_W   = 8;
    localparam int unsigned ADC_W  = 12;
    localparam int unsigned WORD_W = 1 + CH_W + RISE_W + TS_W + ADC_W;

    // Metadata captured for a channel when the scan picks it.
    typedef struct packed {
        logic              go;
        logic              hit;
        logic [CH_W-1:0]   ch;
        logic [RISE_W-1:0] rise;
        logic [TS_W-1:0]   ts;
    } meta_t;

    // Field order of the serial word, MSB first.
    function automatic logic [WORD_W-1:0] pack_word(input meta_t m, input logic [ADC_W-1:0] adc);
        return {m.hit, m.ch, m.rise, m.ts, adc};
    endfunction

endpackage

// File: rtl/sro_period_timer.sv
module sro_period_timer #(
    parameter int unsigned PERIOD = 34
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(PERIOD - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == CW'(PERIOD - 1));

endmodule

// File: rtl/sro_scan.sv
module sro_scan
    import sro_pkg::*;
#(
    parameter int unsigned NUM_CH = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] req_in,
    input  logic [NUM_CH-1:0] hit_in,
    input  logic [RISE_W-1:0] rise_in,
    input  logic [TS_W-1:0]   ts_in,
    output logic [CH_W-1:0]   pick_ch,
    output meta_t             sel_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pending;
        logic [NUM_CH-1:0] hit_mask;
        meta_t             sel;
    } scan_t;

    scan_t st_d, st_q;

    logic [CH_W-1:0] pick;
    logic            any;

    // Lowest pending channel wins.
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (st_q.pending[i]) begin
                pick = CH_W'(i);
            end
        end
        any = |st_q.pending;
    end

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (!any) begin
                // Frame exhausted: load the next one, no pick this period.
                st_d.pending  = req_in;
                st_d.hit_mask = hit_in;
                st_d.sel      = '0;
            end else begin
                st_d.pending[pick] = 1'b0;
                st_d.sel.go        = 1'b1;
                st_d.sel.hit       = st_q.hit_mask[pick];
                st_d.sel.ch        = pick;
                st_d.sel.rise      = rise_in;
                st_d.sel.ts        = ts_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pick_ch = pick;
    assign sel_o   = st_q.sel;

endmodule

// File: rtl/sro_meta_pipe.sv
module sro_meta_pipe
    import sro_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  meta_t in_m,
    output meta_t out_m
);
    // Stage 0 is the pick register in the scan; this adds DEPTH-1 more.
    generate
        if (DEPTH <= 1) begin : g_direct
            assign out_m = in_m;
        end else begin : g_chain
            localparam int unsigned NREG = DEPTH - 1;

            typedef struct packed {
                meta_t [NREG-1:0] stg;
            } pipe_t;

            pipe_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (tick) begin
                    st_d.stg[0] = in_m;
                    for (int i = 1; i < int'(NREG); i++) begin
                        st_d.stg[i] = st_q.stg[i-1];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign out_m = st_q.stg[NREG-1];
        end
    endgenerate

endmodule

// File: rtl/sro_shifter.sv
module sro_shifter
    import sro_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  meta_t            m,
    input  logic [ADC_W-1:0] adc,
    output logic             dout,
    output logic             dout_valid
);
    localparam int unsigned PW = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              vld;
        logic [PW-1:0]     pos;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.sr  = m.go ? pack_word(m, adc) : '0;
            st_d.vld = m.go;
            st_d.pos = '0;
        end else if (st_q.vld) begin
            st_d.sr  = {st_q.sr[WORD_W-2:0], 1'b0};
            st_d.pos = st_q.pos + 1'b1;
            if (st_q.pos == PW'(WORD_W - 1)) begin
                st_d.vld = 1'b0;
                st_d.sr  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.sr[WORD_W-1];
    assign dout_valid = st_q.vld;

endmodule

// File: rtl/sparse_readout_serializer.sv
module sparse_readout_serializer
    import sro_pkg::*;
#(
    parameter int unsigned NUM_CH  = 100,
    parameter int unsigned PERIOD  = 34,
    parameter int unsigned ADC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_in,
    input  logic [NUM_CH-1:0] hit_in,
    output logic [CH_W-1:0]   pick_ch,
    input  logic [RISE_W-1:0] rise_in,
    input  logic [TS_W-1:0]   ts_in,
    output logic [CH_W-1:0]   conv_ch,
    output logic              conv_go,
    input  logic [ADC_W-1:0]  adc_in,
    output logic              dout,
    output logic              dout_valid
);
    logic  tick;
    meta_t sel;
    meta_t aligned;

    sro_period_timer #(.PERIOD(PERIOD)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sro_scan #(.NUM_CH(NUM_CH)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .req_in  (req_in),
        .hit_in  (hit_in),
        .rise_in (rise_in),
        .ts_in   (ts_in),
        .pick_ch (pick_ch),
        .sel_o   (sel)
    );

    sro_meta_pipe #(.DEPTH(ADC_LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .in_m  (sel),
        .out_m (aligned)
    );

    sro_shifter u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .m          (aligned),
        .adc        (adc_in),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    assign conv_ch = sel.ch;
    assign conv_go = sel.go;

endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
    parameter int unsigned NUM_CH = 100,
    parameter int unsigned CH_W   = 7,
    parameter int unsigned WORD_W = 34,
    parameter int unsigned PERIOD = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NUM_CH-1:0] req_in,
    input logic [CH_W-1:0]   conv_ch,
    input logic              conv_go,
    input logic              dout,
    input logic              dout_valid
);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic [CW-1:0]     cyc_q;
    logic              tick_prev_q;
    logic [NUM_CH-1:0] cand_q;
    logic [NUM_CH-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q       <= '0;
            tick_prev_q <= 1'b0;
            cand_q      <= '0;
            frame_q     <= '0;
        end else begin
            if (tick) begin
                cyc_q <= '0;
            end else if (cyc_q != CW'(PERIOD)) begin
                cyc_q <= cyc_q + 1'b1;
            end
            tick_prev_q <= tick;
            if (tick) begin
                cand_q <= req_in;
            end
            if (tick_prev_q && !conv_go) begin
                frame_q <= cand_q;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!dout_valid && !dout && !conv_go); // R1
        end
    end

    AST_VALID_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cyc_q < CW'(WORD_W - 1)) |=> $stable(dout_valid)); // R3

    AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (cyc_q < CW'(WORD_W))); // R3

    AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(conv_ch) && $stable(conv_go))); // R9

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && conv_go) |=> (!conv_go || conv_ch > $past(conv_ch))); // R4

    AST_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> frame_q[conv_ch]); // R5

endmodule

bind sparse_readout_serializer sro_checker #(
    .NUM_CH (NUM_CH),
    .CH_W   (sro_pkg::CH_W),
    .WORD_W (sro_pkg::WORD_W),
    .PERIOD (PERIOD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .req_in     (req_in),
    .conv_ch    (conv_ch),
    .conv_go    (conv_go),
    .dout       (dout),
    .dout_valid (dout_valid)
);

// File: tb/sparse_readout_serializer_test.sv
module sparse_readout_serializer_test;

    localparam int N   = 100;
    localparam int PER = 34;
    localparam int LAT = 2;   // the converter model below is written for two periods
    localparam int WW  = 34;

    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] hit;
    } case_t;

    localparam int NCASE = 6;
    localparam case_t CASES [NCASE] = '{
        '{req: (100'b1 << 0),  hit: (100'b1 << 0)},
        '{req: (100'b1 << 99), hit: '0},
        '{req: (100'b1 << 3) | (100'b1 << 4) | (100'b1 << 13) | (100'b1 << 14) | (100'b1 << 50),
          hit: (100'b1 << 4) | (100'b1 << 14)},
        '{req: ((100'b1 << 20) - 100'b1) << 40, hit: (100'b1 << 50)},
        '{req: {100{1'b1}}, hit: {50{2'b10}}},
        '{req: '0, hit: {100{1'b1}}}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_in = '0;
    logic [N-1:0]  hit_in = '0;
    logic [6:0]    pick_ch;
    logic [5:0]    rise_in;
    logic [7:0]    ts_in;
    logic [6:0]    conv_ch;
    logic          conv_go;
    logic [11:0]   adc_in;
    logic          dout;
    logic          dout_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int sched_ch  [0:255];
    bit sched_hit [0:255];

    always #2.5 clk = ~clk;

    sparse_readout_serializer #(.NUM_CH(N), .PERIOD(PER), .ADC_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .hit_in(hit_in),
        .pick_ch(pick_ch), .rise_in(rise_in), .ts_in(ts_in),
        .conv_ch(conv_ch), .conv_go(conv_go), .adc_in(adc_in),
        .dout(dout), .dout_valid(dout_valid)
    );

    // Front-end model: metadata depends only on the addressed channel.
    assign rise_in = 6'((int'(pick_ch) * 5 + 3) % 64);
    assign ts_in   = 8'((int'(pick_ch) * 11 + 7) % 256);

    // Converter model: result ready two boundaries after the pick (R6, R10).
    int         bcnt;
    logic [11:0] adc_q;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt  <= 0;
            adc_q <= '0;
        end else begin
            bcnt <= (bcnt == PER - 1) ? 0 : bcnt + 1;
            if (bcnt == PER - 1) adc_q <= 12'((int'(conv_ch) * 41 + 100) % 4096);
        end
    end
    assign adc_in = adc_q;

    function automatic logic [WW-1:0] exp_word(input int c, input bit h);
        return {h, 7'(c), 6'((c * 5 + 3) % 64), 8'((c * 11 + 7) % 256), 12'((c * 41 + 100) % 4096)};
    endfunction

    function automatic int nth_set(input logic [N-1:0] v, input int n);
        int seen = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                if (seen == n) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dout_valid && !dout && !conv_go, "R1 outputs during reset",
            WW'({dout_valid, dout, conv_go}), '0);
        rst_n = 1'b1;
    endtask

    task automatic run_windows(input int nwin, input int chg_win,
                               input logic [N-1:0] nreq, input logic [N-1:0] nhit, input string tag);
        logic [WW-1:0] got;
        logic [WW-1:0] gv;
        logic [WW-1:0] ev;
        logic [WW-1:0] ew;
        int            s;
        do_reset();
        repeat (PER - 1) @(posedge clk);
        for (int w = 0; w < nwin; w++) begin
            if (w == chg_win) begin
                req_in = nreq;
                hit_in = nhit;
            end
            for (int b = 0; b < WW; b++) begin
                @(posedge clk);
                @(negedge clk);
                got[WW-1-b] = dout;
                gv[WW-1-b]  = dout_valid;
                if (b == 17) begin
                    if (sched_ch[w] < 0) begin
                        chk(!conv_go, $sformatf("R9 %s window %0d conv_go", tag, w),
                            WW'(conv_go), '0);
                    end else begin
                        chk(conv_go && int'(conv_ch) == sched_ch[w],
                            $sformatf("R9/R4/R5 %s window %0d conv_ch", tag, w),
                            WW'({conv_go, conv_ch}), WW'({1'b1, 7'(sched_ch[w])}));
                    end
                end
            end
            s  = w - LAT;
            ev = (s >= 0 && sched_ch[s] >= 0) ? '1 : '0;
            chk(gv == ev, $sformatf("R3/R7/R10 %s window %0d valid", tag, w), gv, ev);
            if (s >= 0 && sched_ch[s] >= 0) begin
                ew = exp_word(sched_ch[s], sched_hit[s]);
                chk(got == ew, $sformatf("R2/R6/R8 %s window %0d word", tag, w), got, ew);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Table walk: constant request vector per run.
        for (int c = 0; c < NCASE; c++) begin
            int k;
            int nwin;
            req_in = CASES[c].req;
            hit_in = CASES[c].hit;
            k      = $countones(CASES[c].req);
            nwin   = LAT + 2 * (k + 1) + 1;
            for (int s = 0; s < nwin; s++) begin
                int j;
                j = s % (k + 1);
                if (j == 0) begin
                    sched_ch[s]  = -1;
                    sched_hit[s] = 1'b0;
                end else begin
                    sched_ch[s]  = nth_set(CASES[c].req, j - 1);
                    sched_hit[s] = CASES[c].hit[sched_ch[s]];
                end
            end
            run_windows(nwin, -1, '0, '0, $sformatf("case%0d", c));
        end

        // Directed: vectors change mid-frame, only the next load uses them (R5, R8).
        req_in = (100'b1 << 5) | (100'b1 << 6) | (100'b1 << 7);
        hit_in = (100'b1 << 6);
        for (int s = 0; s < 10; s++) begin
            sched_ch[s]  = -1;
            sched_hit[s] = 1'b0;
        end
        sched_ch[1] = 5;  sched_hit[1] = 1'b0;
        sched_ch[2] = 6;  sched_hit[2] = 1'b1;
        sched_ch[3] = 7;  sched_hit[3] = 1'b0;
        sched_ch[5] = 10; sched_hit[5] = 1'b1;
        sched_ch[7] = 10; sched_hit[7] = 1'b1;
        sched_ch[9] = 10; sched_hit[9] = 1'b1;
        run_windows(10, 2, (100'b1 << 10), (100'b1 << 7) | (100'b1 << 10), "midframe_R5");

        // Directed: reset reapplied after traffic clears the output (R1).
        do_reset();
        @(negedge clk);
        chk(!dout_valid && !conv_go, "R1 first cycle after release", WW'({dout_valid, conv_go}), '0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule